// File: doc/BRIEF.md
# Binary/BCD Add-Subtract Unit

This block is the add/subtract slice of an 8-bit accumulator datapath. A one-cycle `start` pulse presents two operands, a carry input and three mode bits. The mode bits choose add or subtract, binary or packed-BCD arithmetic, and one of two flag behaviours for decimal work. The unit then returns an 8-bit result and the negative, overflow, zero and carry flags. In subtraction the carry input means "no borrow": a carry of 1 subtracts nothing extra.

The legacy flag variant finishes every operation one cycle after `start`. In decimal mode it takes negative, overflow and zero from the uncorrected binary sum, and only the carry from the decimal-adjusted result. The corrected variant in decimal mode derives all four flags from the adjusted result. To do so it spends one extra cycle, which it signals on `extra_cycle`, before `done`. With decimal mode off, both variants behave identically and finish in one cycle.

A small state machine runs the sequence. Its states are `S_IDLE`, `S_EXTRA` and `S_DONE`. It has four transitions:
- `S_IDLE` goes to `S_DONE` when `start` arrives for any operation that needs no extra cycle.
- `S_IDLE` goes to `S_EXTRA` when `start` arrives with decimal mode and the corrected variant both set.
- `S_EXTRA` goes to `S_DONE` unconditionally.
- `S_DONE` goes to `S_IDLE` unconditionally.

The unit accepts `start` only in `S_IDLE`.

Top module: `bcd_addsub_alu`

## Requirements
- R1: Binary add: result = (A + M + C) mod 256. C is the carry out of bit 7. N is bit 7 of the result. Z is 1 when the result is 0x00. V is bit 7 of (A^R)&(M^R).
- R2: Binary subtract: result = (A + ~M + C) mod 256, with C = 1 meaning no borrow. The C output is 1 when no borrow occurred. V is bit 7 of (A^R)&(~M^R), and N and Z follow the rules of R1.
- R3: Decimal add, applied to each nibble from low to high: s = a + m + carry. If s > 9 then s = s + 6. The digit is s mod 16, and the carry into the next nibble is 1 when s >= 16. This rule also gives a fixed result for nibbles above 9. The final carry is the C output.
- R4: Decimal subtract, applied to each nibble from low to high: d = a - m - borrow. If d < 0, borrow out is 1 and the digit is (d - 6) mod 16; otherwise the digit is d. The initial borrow is 1 - C, and the C output is 1 - final borrow.
- R5: Legacy variant (`fixed_mode` = 0) with decimal mode on: the result and C follow R3 or R4. N, Z and V are taken from the binary result of R1 or R2.
- R6: Corrected variant (`fixed_mode` = 1) with decimal mode on: the result and C follow R3 or R4. N, Z and V are computed as in R1 and R2, but on the decimal result R.
- R7: With decimal mode on and `fixed_mode` = 1, `extra_cycle` is high for exactly one cycle, starting the cycle after `start` is accepted, and `done` follows in the next cycle. In every other mode `done` rises the cycle after `start` is accepted, and `extra_cycle` stays low.
- R8: `done` is high for exactly one cycle. The result and flags keep their values until a later `start` is accepted.
- R9: A `start` that arrives while an operation is in `S_EXTRA` or `S_DONE` is ignored. It changes no output and produces no later `done`.
- R10: While reset is asserted, the result is 0x00, all four flags are 0, and both `done` and `extra_cycle` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation with the operands presented this cycle |
| op_sub | input | 1 | 0 = add with carry, 1 = subtract with borrow |
| dec_mode | input | 1 | 1 = packed-BCD arithmetic |
| fixed_mode | input | 1 | 0 = legacy flags, 1 = corrected flags with one extra cycle |
| a_in | input | 8 | Accumulator operand |
| m_in | input | 8 | Memory operand |
| c_in | input | 1 | Carry in; for subtract, 1 = no borrow |
| result | output | 8 | Sum or difference |
| flag_n | output | 1 | Negative flag |
| flag_v | output | 1 | Signed overflow flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry / no-borrow flag |
| extra_cycle | output | 1 | High during the added decimal-flag cycle |
| done | output | 1 | One-cycle pulse when outputs are valid |

## Verification
The assertions check the handshake timing on every cycle:
- `extra_cycle` lasts one cycle and is always followed by `done`.
- `done` lasts one cycle, and the outputs hold steady in the cycle after it.
- `done` and `extra_cycle` are never high together.
- After an extra cycle, N and Z agree with the delivered decimal result.

The arithmetic itself can only be shown by the bench's scenarios. These cover binary and decimal add and subtract, nibbles above 9, and where the legacy and corrected flags differ. They also cover starts that arrive while the unit is busy.

// File: rtl/alu_pkg.sv
package alu_pkg;
    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_EXTRA = 2'd1,
        S_DONE  = 2'd2
    } alu_state_t;
endpackage

// File: rtl/addsub_bin.sv
module addsub_bin #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] m,
    input  logic         c_in,
    input  logic         op_sub,
    output logic [W-1:0] sum,
    output logic         c_out,
    output logic         mp_msb
);
    logic [W-1:0] mp;
    logic [W:0]   full;

    always_comb begin
        mp     = op_sub ? ~m : m;
        full   = {1'b0, a} + {1'b0, mp} + {{W{1'b0}}, c_in};
        sum    = full[W-1:0];
        c_out  = full[W];
        mp_msb = mp[W-1];
    end
endmodule

// File: rtl/dec_digit.sv
module dec_digit (
    input  logic [3:0] a_d,
    input  logic [3:0] m_d,
    input  logic       c_in,
    input  logic       op_sub,
    output logic [3:0] digit,
    output logic       c_out
);
    logic [4:0] s5;
    logic [5:0] s6;
    logic [4:0] d5;

    always_comb begin
        s5 = {1'b0, a_d} + {1'b0, m_d} + {4'b0, c_in};
        s6 = (s5 > 5'd9) ? ({1'b0, s5} + 6'd6) : {1'b0, s5};
        d5 = {1'b0, a_d} - {1'b0, m_d} - {4'b0, ~c_in};
        if (op_sub) begin
            digit = d5[4] ? (d5[3:0] - 4'd6) : d5[3:0];
            c_out = ~d5[4];
        end else begin
            digit = s6[3:0];
            c_out = |s6[5:4];
        end
    end
endmodule

// File: rtl/dec_chain.sv
module dec_chain #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] m,
    input  logic         c_in,
    input  logic         op_sub,
    output logic [W-1:0] res,
    output logic         c_out
);
    localparam int DIGITS = W / 4;

    logic [DIGITS:0] carry;

    assign carry[0] = c_in;

    for (genvar g = 0; g < DIGITS; g++) begin : g_digit
        dec_digit u_dig (
            .a_d   (a[4*g +: 4]),
            .m_d   (m[4*g +: 4]),
            .c_in  (carry[g]),
            .op_sub(op_sub),
            .digit (res[4*g +: 4]),
            .c_out (carry[g+1])
        );
    end

    assign c_out = carry[DIGITS];
endmodule

// File: rtl/bcd_addsub_alu.sv
module bcd_addsub_alu #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         op_sub,
    input  logic         dec_mode,
    input  logic         fixed_mode,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] m_in,
    input  logic         c_in,
    output logic [W-1:0] result,
    output logic         flag_n,
    output logic         flag_v,
    output logic         flag_z,
    output logic         flag_c,
    output logic         extra_cycle,
    output logic         done
);
    import alu_pkg::*;

    localparam int MSB = W - 1;

    alu_state_t state, nxt;

    logic [W-1:0] bin_sum;
    logic         bin_c;
    logic         mp_msb;
    logic [W-1:0] dec_res;
    logic         dec_c;
    logic         a_msb_q;
    logic         mp_msb_q;
    logic         need_extra;

    addsub_bin #(.W(W)) u_bin (
        .a     (a_in),
        .m     (m_in),
        .c_in  (c_in),
        .op_sub(op_sub),
        .sum   (bin_sum),
        .c_out (bin_c),
        .mp_msb(mp_msb)
    );

    dec_chain #(.W(W)) u_dec (
        .a     (a_in),
        .m     (m_in),
        .c_in  (c_in),
        .op_sub(op_sub),
        .res   (dec_res),
        .c_out (dec_c)
    );

    assign need_extra = dec_mode & fixed_mode;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:  if (start) nxt = need_extra ? S_EXTRA : S_DONE;
            S_EXTRA: nxt = S_DONE;
            S_DONE:  nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result      <= '0;
            flag_n      <= 1'b0;
            flag_v      <= 1'b0;
            flag_z      <= 1'b0;
            flag_c      <= 1'b0;
            extra_cycle <= 1'b0;
            done        <= 1'b0;
            a_msb_q     <= 1'b0;
            mp_msb_q    <= 1'b0;
        end else begin
            unique case (state)
                S_IDLE: begin
                    if (start) begin
                        a_msb_q  <= a_in[MSB];
                        mp_msb_q <= mp_msb;
                        result   <= dec_mode ? dec_res : bin_sum;
                        flag_c   <= dec_mode ? dec_c : bin_c;
                        if (need_extra) begin
                            extra_cycle <= 1'b1;
                        end else begin
                            flag_n <= bin_sum[MSB];
                            flag_z <= (bin_sum == '0);
                            flag_v <= (a_in[MSB] ^ bin_sum[MSB]) & (mp_msb ^ bin_sum[MSB]);
                            done   <= 1'b1;
                        end
                    end
                end
                S_EXTRA: begin
                    flag_n      <= result[MSB];
                    flag_z      <= (result == '0);
                    flag_v      <= (a_msb_q ^ result[MSB]) & (mp_msb_q ^ result[MSB]);
                    extra_cycle <= 1'b0;
                    done        <= 1'b1;
                end
                S_DONE: begin
                    done <= 1'b0;
                end
                default: begin
                    done        <= 1'b0;
                    extra_cycle <= 1'b0;
                end
            endcase
        end
    end
endmodule

// File: rtl/alu_sva.sv
module alu_sva #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] result,
    input logic         flag_n,
    input logic         flag_v,
    input logic         flag_z,
    input logic         flag_c,
    input logic         extra_cycle,
    input logic         done
);
    // R7
    extra_then_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        extra_cycle |=> (done && !extra_cycle));

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    hold_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> ($stable(result) && $stable(flag_n) && $stable(flag_v)
                  && $stable(flag_z) && $stable(flag_c)));

    // R7
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, extra_cycle}));

    // R6
    fixed_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(extra_cycle)) |-> ((flag_z == (result == '0)) && (flag_n == result[W-1])));
endmodule

bind bcd_addsub_alu alu_sva #(.W(W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .result     (result),
    .flag_n     (flag_n),
    .flag_v     (flag_v),
    .flag_z     (flag_z),
    .flag_c     (flag_c),
    .extra_cycle(extra_cycle),
    .done       (done)
);

// File: tb/bcd_addsub_alu_tb_top.sv
module bcd_addsub_alu_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       op_sub = 1'b0;
    logic       dec_mode = 1'b0;
    logic       fixed_mode = 1'b0;
    logic [7:0] a_in = 8'h00;
    logic [7:0] m_in = 8'h00;
    logic       c_in = 1'b0;
    logic [7:0] result;
    logic       flag_n, flag_v, flag_z, flag_c, extra_cycle, done;

    int total = 0;
    int bad = 0;
    logic [7:0] cap_r;
    logic [3:0] cap_f;

    always #10 clk = ~clk;

    bcd_addsub_alu dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .op_sub(op_sub),
        .dec_mode(dec_mode), .fixed_mode(fixed_mode), .a_in(a_in),
        .m_in(m_in), .c_in(c_in), .result(result), .flag_n(flag_n),
        .flag_v(flag_v), .flag_z(flag_z), .flag_c(flag_c),
        .extra_cycle(extra_cycle), .done(done)
    );

    // {sub, dec, fixed, carry} nibble, then A, then M
    localparam logic [19:0] VEC [16] = '{
        20'h0_50_50, 20'h1_FF_00, 20'h0_80_80, 20'h3_7F_00,
        20'h9_50_30, 20'h9_50_70, 20'h8_00_00, 20'h5_58_46,
        20'h4_99_01, 20'h4_0F_0F, 20'hD_46_12, 20'hC_50_50,
        20'h7_99_00, 20'h6_79_14, 20'hF_00_01, 20'hE_20_1F
    };

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // returns {r[7:0], n, v, z, c}
    function automatic logic [11:0] model(input bit sub, input bit dec, input bit fix,
                                          input bit c, input int a, input int m);
        int mm, sum, rb, cb, lo, hi, cl, bl, rd, cd, r, rf;
        bit n, v, z;
        mm  = sub ? (255 - m) : m;
        sum = a + mm + c;
        rb  = sum % 256;
        cb  = sum / 256;
        if (!sub) begin
            lo = (a % 16) + (m % 16) + c;
            if (lo > 9) lo = lo + 6;
            cl = (lo >= 16) ? 1 : 0;
            hi = (a / 16) + (m / 16) + cl;
            if (hi > 9) hi = hi + 6;
            cd = (hi >= 16) ? 1 : 0;
        end else begin
            lo = (a % 16) - (m % 16) - (1 - c);
            bl = (lo < 0) ? 1 : 0;
            if (bl == 1) lo = lo - 6;
            hi = (a / 16) - (m / 16) - bl;
            cd = (hi < 0) ? 0 : 1;
            if (hi < 0) hi = hi - 6;
        end
        rd = ((hi & 15) * 16) + (lo & 15);
        r  = dec ? rd : rb;
        rf = (dec && fix) ? rd : rb;
        n  = (rf >= 128);
        z  = (rf == 0);
        v  = (((a ^ rf) & (mm ^ rf) & 128) != 0);
        return {r[7:0], n, v, z, (dec ? cd[0] : cb[0])};
    endfunction

    // starts and ends at a negedge with the unit idle
    task automatic run_op(input bit sub, input bit dec, input bit fix,
                          input bit c, input logic [7:0] a, input logic [7:0] m);
        op_sub = sub; dec_mode = dec; fixed_mode = fix; c_in = c;
        a_in = a; m_in = m; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (dec && fix) begin
            check("R7 extra_cycle after start", {30'b0, extra_cycle, done}, 2);
            @(negedge clk);
        end
        check("R7 done timing", {30'b0, extra_cycle, done}, 1);
        cap_r = result;
        cap_f = {flag_n, flag_v, flag_z, flag_c};
        @(negedge clk);
        check("R8 done one cycle", {31'b0, done}, 0);
        check("R8 outputs hold", {20'b0, result, flag_n, flag_v, flag_z, flag_c}, {20'b0, cap_r, cap_f});
    endtask

    initial begin
        #4000000;
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [11:0] e;
        string rt, ft;
        @(negedge clk);
        @(negedge clk);
        // R10 reset state
        check("R10 reset outputs", {16'b0, result, flag_n, flag_v, flag_z, flag_c, extra_cycle, done}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < 16; i++) begin
            logic [19:0] w;
            w = VEC[i];
            run_op(w[19], w[18], w[17], w[16], w[15:8], w[7:0]);
            e = model(w[19], w[18], w[17], w[16], int'(w[15:8]), int'(w[7:0]));
            if (w[18]) begin
                rt = w[19] ? "R4 result/carry" : "R3 result/carry";
                ft = w[17] ? "R6 flags" : "R5 flags";
            end else begin
                rt = w[19] ? "R2 result/carry" : "R1 result/carry";
                ft = w[19] ? "R2 flags" : "R1 flags";
            end
            check(rt, {cap_r, cap_f[0]}, {e[11:4], e[0]});
            check(ft, {29'b0, cap_f[3:1]}, {29'b0, e[3:1]});
        end

        // R5: 58+46+1 decimal legacy -> 05, C=1, N=1 V=1 Z=0 from binary 9F
        run_op(1'b0, 1'b1, 1'b0, 1'b1, 8'h58, 8'h46);
        check("R5 legacy decimal add", {cap_r, cap_f}, {8'h05, 4'b1101});
        // R6: same operands corrected -> 05, N=0 V=0 Z=0 C=1
        run_op(1'b0, 1'b1, 1'b1, 1'b1, 8'h58, 8'h46);
        check("R6 corrected decimal add", {cap_r, cap_f}, {8'h05, 4'b0001});
        // R6: 99+00+1 corrected -> 00, Z=1, C=1
        run_op(1'b0, 1'b1, 1'b1, 1'b1, 8'h99, 8'h00);
        check("R6 corrected zero", {cap_r, cap_f}, {8'h00, 4'b0011});
        // R5: same legacy -> Z=0, N=1 from binary 9A
        run_op(1'b0, 1'b1, 1'b0, 1'b1, 8'h99, 8'h00);
        check("R5 legacy zero from binary", {cap_r, cap_f}, {8'h00, 4'b1001});
        // R4: 00-01 no borrow in -> 99, C=0
        run_op(1'b1, 1'b1, 1'b1, 1'b1, 8'h00, 8'h01);
        check("R4 decimal wrap", {cap_r, cap_f}, {8'h99, 4'b1000});
        // R3: non-BCD digits 0F+0F -> 14, C=0
        run_op(1'b0, 1'b1, 1'b0, 1'b0, 8'h0F, 8'h0F);
        check("R3 non-BCD nibble", {cap_r, cap_f[0]}, {8'h14, 1'b0});

        // R9: starts while busy are ignored
        op_sub = 1'b0; dec_mode = 1'b1; fixed_mode = 1'b1; c_in = 1'b0;
        a_in = 8'h12; m_in = 8'h34; start = 1'b1;
        @(negedge clk);
        a_in = 8'h77; m_in = 8'h77; dec_mode = 1'b0;
        @(negedge clk);
        check("R9 start in extra ignored", {23'b0, result, done}, {23'b0, 8'h46, 1'b1});
        a_in = 8'hFF; m_in = 8'h01;
        @(negedge clk);
        start = 1'b0;
        check("R9 start in done ignored", {23'b0, result, done}, {23'b0, 8'h46, 1'b0});
        @(negedge clk);
        check("R9 no late done", {22'b0, result, done, extra_cycle}, {22'b0, 8'h46, 2'b00});
        repeat (3) @(negedge clk);
        check("R8 idle hold", {20'b0, result, flag_n, flag_v, flag_z, flag_c}, {20'b0, 8'h46, 4'b0000});

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule